// File: doc/BRIEF.md
# Local-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps its own recent outcome pattern for each group of branches. Low bits of the branch address pick one of several shift registers, and each register records the latest outcomes of the branches that map to it. That recorded pattern, not the address and not a history shared by all branches, selects a 2-bit saturating counter in a shared table. The top bit of that counter is the guess. The guess therefore repeats what happened the last time a branch showed the same recent pattern.

Fetch presents an address and reads the guess back in the same cycle, with no register in the path. When the branch resolves, the back end presents the branch address and its real direction on the resolve port. The counter selected by the branch's current pattern moves one step toward that direction. On the same clock edge the real outcome enters that branch's history register.

Top module: `lhist_bpred`

## Requirements
- R1: After reset, every history register holds zero and every counter holds the weakly-not-taken value 2'b01. All predictions are not-taken, and a single taken resolve is enough to turn the counter it touches to taken.
- R2: With SEL_BITS = k, the history register is selected by PC bits [k+1:2]. Addresses that differ only in other bits share one history register.
- R3: The counter table is indexed only by the selected history value. Branches with different addresses but equal history read and train the same counter.
- R4: pred_taken is bit 1 of the counter selected by pred_pc. It is valid in the same cycle that pred_pc is presented.
- R5: A taken resolve adds one to the indexed counter. A counter at 3 stays at 3.
- R6: A not-taken resolve subtracts one from the indexed counter. A counter at 0 stays at 0.
- R7: A resolve updates the counter indexed by the history held before that resolve. The history register then shifts left by one, takes the actual outcome into bit 0 (1 = taken), and drops its oldest bit.
- R8: While upd_valid is low, upd_pc and upd_taken have no effect on any history register or counter.
- R9: When a prediction and a resolve fall in the same cycle, pred_taken reflects the state before that resolve. The resolve is visible from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| pred_pc | input | PC_W | Address of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual direction of the resolved branch, 1 = taken |

## Verification
A history register holding a wrong bit does not show up right away. It shows up as a wrong guess the next time any branch that maps to that register is predicted, because the register then reads a different counter. A counter that has drifted, for example one that wraps instead of saturating, changes pred_taken only when its top bit differs from the correct value. That can take up to two further resolves on the same pattern before a port-level mismatch appears. The bench therefore probes addresses whose history is known to equal the pattern just trained, and it compares every cycle against a reference model of both tables.

// File: rtl/lhp_pkg.sv
`timescale 1ns/1ps
// Package: shared types and the saturating step rule for the predictor.
// Assumes 2-bit counters where values 2 and 3 mean "taken".
package lhp_pkg;

    typedef logic [1:0] ctr2_t;

    localparam ctr2_t CTR_MAX   = 2'd3;
    localparam ctr2_t CTR_MIN   = 2'd0;
    localparam ctr2_t CTR_RESET = 2'd1;   // weakly not taken

    // One saturating step toward the resolved direction.
    function automatic ctr2_t ctr_step(input ctr2_t cur, input logic taken);
        ctr2_t nxt;
        if (taken) begin
            nxt = (cur == CTR_MAX) ? CTR_MAX : cur + 2'd1;
        end else begin
            nxt = (cur == CTR_MIN) ? CTR_MIN : cur - 2'd1;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/lhp_hist_bank.sv
`timescale 1ns/1ps
// Module: bank of per-branch outcome shift registers.
// One combinational read port for the prediction side and one read-modify-write
// port for the resolve side. Assumes HIST_LEN >= 2. On a write, the newest
// outcome enters bit 0 and the oldest bit is dropped.
module lhp_hist_bank #(
    parameter int SEL_BITS = 4,
    parameter int HIST_LEN = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SEL_BITS-1:0] rd_sel,
    output logic [HIST_LEN-1:0] rd_hist,
    input  logic                wr_en,
    input  logic [SEL_BITS-1:0] wr_sel,
    input  logic                wr_taken,
    output logic [HIST_LEN-1:0] wr_hist
);
    localparam int NREG = 1 << SEL_BITS;

    logic [HIST_LEN-1:0] hist_q [NREG];

    // Read ports: history for the predicted branch and for the resolving one.
    assign rd_hist = hist_q[rd_sel];
    assign wr_hist = hist_q[wr_sel];

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        // Shift the resolved outcome into register r when it is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hist_q[r] <= '0;
            end else if (wr_en && (wr_sel == SEL_BITS'(r))) begin
                hist_q[r] <= {hist_q[r][HIST_LEN-2:0], wr_taken};
            end
        end

        // An unaddressed register keeps its value.
        p_hist_hold_r8 : assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && (wr_sel == SEL_BITS'(r))) |=> $stable(hist_q[r]));
    end

    // The written register holds the old pattern shifted, with the outcome at bit 0.
    p_hist_shift_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (hist_q[$past(wr_sel)][0] == $past(wr_taken)) &&
                  (hist_q[$past(wr_sel)][HIST_LEN-1:1] == $past(wr_hist[HIST_LEN-2:0])));

endmodule

// File: rtl/lhp_pattern_table.sv
`timescale 1ns/1ps
// Module: table of 2-bit saturating direction counters indexed by a history pattern.
// The read is combinational; the update is one saturating step on the clock edge.
// Assumes the index width equals the history length.
module lhp_pattern_table
    import lhp_pkg::*;
#(
    parameter int HIST_LEN = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [HIST_LEN-1:0] rd_idx,
    output logic                rd_taken,
    input  logic                wr_en,
    input  logic [HIST_LEN-1:0] wr_idx,
    input  logic                wr_taken
);
    localparam int DEPTH = 1 << HIST_LEN;

    ctr2_t ctr_q [DEPTH];
    ctr2_t wr_old;

    // Prediction is the top bit of the addressed counter.
    assign rd_taken = ctr_q[rd_idx][1];
    // Value that the current update starts from.
    assign wr_old   = ctr_q[wr_idx];

    for (genvar e = 0; e < DEPTH; e++) begin : g_ctr
        // Step counter e toward the resolved direction when it is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctr_q[e] <= CTR_RESET;
            end else if (wr_en && (wr_idx == HIST_LEN'(e))) begin
                ctr_q[e] <= ctr_step(ctr_q[e], wr_taken);
            end
        end

        // Counters not addressed by an update stay put.
        p_ctr_hold_r3 : assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && (wr_idx == HIST_LEN'(e))) |=> $stable(ctr_q[e]));
    end

    // A taken update of a counter at its ceiling leaves it there.
    p_ctr_ceiling_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && (wr_old == CTR_MAX)) |=> (ctr_q[$past(wr_idx)] == CTR_MAX));

    // A taken update below the ceiling adds exactly one.
    p_ctr_inc_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && (wr_old != CTR_MAX)) |=>
            (ctr_q[$past(wr_idx)] == ctr2_t'($past(wr_old) + 2'd1)));

    // A not-taken update of a counter at its floor leaves it there.
    p_ctr_floor_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && (wr_old == CTR_MIN)) |=> (ctr_q[$past(wr_idx)] == CTR_MIN));

    // A not-taken update above the floor subtracts exactly one.
    p_ctr_dec_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && (wr_old != CTR_MIN)) |=>
            (ctr_q[$past(wr_idx)] == ctr2_t'($past(wr_old) - 2'd1)));

endmodule

// File: rtl/lhist_bpred.sv
`timescale 1ns/1ps
// Module: two-level local-history branch direction predictor (top).
// Low PC bits above the instruction alignment select a history register; the
// history value indexes a shared counter table. Both reads are combinational.
// A resolve updates the counter picked by the pre-update history, then shifts
// the outcome into that history register, both on the same edge.
// Assumes 4-byte aligned branch addresses and PC_W >= SEL_BITS + 2.
module lhist_bpred #(
    parameter int PC_W     = 32,
    parameter int SEL_BITS = 4,
    parameter int HIST_LEN = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);
    localparam int SEL_LO = 2;
    localparam int SEL_HI = SEL_BITS + SEL_LO - 1;

    logic [SEL_BITS-1:0] pred_sel;
    logic [SEL_BITS-1:0] upd_sel;
    logic [HIST_LEN-1:0] pred_hist;
    logic [HIST_LEN-1:0] upd_hist;

    // Address slices that pick the history register.
    assign pred_sel = pred_pc[SEL_HI:SEL_LO];
    assign upd_sel  = upd_pc[SEL_HI:SEL_LO];

    lhp_hist_bank #(
        .SEL_BITS (SEL_BITS),
        .HIST_LEN (HIST_LEN)
    ) hist_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_sel   (pred_sel),
        .rd_hist  (pred_hist),
        .wr_en    (upd_valid),
        .wr_sel   (upd_sel),
        .wr_taken (upd_taken),
        .wr_hist  (upd_hist)
    );

    lhp_pattern_table #(
        .HIST_LEN (HIST_LEN)
    ) pht_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (pred_hist),
        .rd_taken (pred_taken),
        .wr_en    (upd_valid),
        .wr_idx   (upd_hist),
        .wr_taken (upd_taken)
    );

    // A resolve on the register being read changes the read history next cycle
    // only through the shift, so its new bit 0 is the outcome just resolved.
    p_same_reg_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && (upd_sel == pred_sel)) |=>
            ($past(pred_sel) != pred_sel) || (pred_hist[0] == $past(upd_taken)));

endmodule

// File: tb/lhist_bpred_tb_top.sv
`timescale 1ns/1ps
module lhist_bpred_tb_top;
    localparam int PC_W     = 32;
    localparam int SEL_BITS = 4;
    localparam int HIST_LEN = 6;
    localparam int NREG     = 1 << SEL_BITS;
    localparam int DEPTH    = 1 << HIST_LEN;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [PC_W-1:0] pred_pc;
    logic            pred_taken;
    logic            upd_valid;
    logic [PC_W-1:0] upd_pc;
    logic            upd_taken;

    int  hist_m [NREG];
    int  ctr_m  [DEPTH];
    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 0;

    always #2.5 clk = ~clk;

    lhist_bpred #(.PC_W(PC_W), .SEL_BITS(SEL_BITS), .HIST_LEN(HIST_LEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
    );

    // Reference: register select from PC bits [SEL_BITS+1:2] (R2).
    function automatic int sel_of(input logic [PC_W-1:0] pc);
        return int'(pc[SEL_BITS+1:2]);
    endfunction

    // Reference prediction: counter at the selected history, taken if >= 2 (R3, R4).
    function automatic bit exp_pred(input logic [PC_W-1:0] pc);
        return ctr_m[hist_m[sel_of(pc)]] >= 2;
    endfunction

    // Reference update: counter at the old history, then shift (R5, R6, R7).
    function automatic void model_upd(input logic [PC_W-1:0] pc, input bit t);
        int s, h;
        s = sel_of(pc);
        h = hist_m[s];
        if (t) ctr_m[h] = (ctr_m[h] == 3) ? 3 : ctr_m[h] + 1;
        else   ctr_m[h] = (ctr_m[h] == 0) ? 0 : ctr_m[h] - 1;
        hist_m[s] = ((h << 1) | int'(t)) & (DEPTH - 1);
    endfunction

    function automatic void model_reset();
        for (int i = 0; i < NREG; i++)  hist_m[i] = 0;
        for (int i = 0; i < DEPTH; i++) ctr_m[i]  = 1;
    endfunction

    // One cycle: drive at the falling edge, check the same-cycle prediction,
    // and apply the resolve to the model for the coming rising edge (R9).
    task automatic cyc(input logic [PC_W-1:0] ppc, input bit v,
                       input logic [PC_W-1:0] upc, input bit t, input string tag);
        bit e;
        @(negedge clk);
        pred_pc = ppc; upd_valid = v; upd_pc = upc; upd_taken = t;
        #1;
        e = exp_pred(ppc);
        n_vec++;
        if (pred_taken !== e) begin
            n_bad++;
            $display("FAIL %s pc=%h actual=%0b expected=%0b", tag, ppc, pred_taken, e);
        end
        if (v) model_upd(upc, t);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R4 actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [PC_W-1:0] pa, pb, pc3;
        void'($urandom(32'h5eed_0447));
        rst_n = 1'b0; pred_pc = '0; upd_valid = 1'b0; upd_pc = '0; upd_taken = 1'b0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: all not taken after reset
        for (int i = 0; i < NREG; i++) cyc(32'(i) << 2, 1'b0, '0, 1'b0, "R1 reset");
        // R1/R9: one taken on register 0, probed in the same cycle
        cyc(32'h100, 1'b1, 32'h100, 1'b1, "R9 same-cycle");
        // R3: another register with history 0 now reads the trained counter (taken)
        cyc(32'h204, 1'b0, '0, 1'b0, "R1 R3 shared counter");
        // R7: register 0 now has history 1 -> counter 1 is untouched
        cyc(32'h100, 1'b0, '0, 1'b0, "R7 shifted history");

        // R2: alias on bits above [5:2]
        pa = 32'h0000_1108; pb = 32'h0000_2208;
        cyc(pa, 1'b1, pb, 1'b1, "R2 alias");
        cyc(pa, 1'b0, '0, 1'b0, "R2 alias");
        cyc(32'h0000_000C, 1'b0, '0, 1'b0, "R2 neighbour");

        // R5: saturate counter at the all-ones pattern and step back once
        pc3 = 32'h0000_0010;
        for (int i = 0; i < 12; i++) cyc(pc3, 1'b1, pc3, 1'b1, "R5 train");
        cyc(pc3, 1'b1, pc3, 1'b0, "R5 step down");
        for (int i = 0; i < 6; i++) cyc(32'h14, 1'b1, 32'h14, 1'b1, "R5 probe train");
        cyc(32'h14, 1'b0, '0, 1'b0, "R5 ceiling");

        // R6: drive counter 0 to its floor, then one taken must not wrap
        for (int i = 0; i < 8; i++) cyc(32'h18, 1'b1, 32'h18, 1'b0, "R6 train");
        cyc(32'h1C, 1'b0, '0, 1'b0, "R6 floor");
        cyc(32'h1C, 1'b1, 32'h18, 1'b1, "R6 floor step");
        cyc(32'h1C, 1'b0, '0, 1'b0, "R6 floor no wrap");

        // R8: updates without valid have no effect
        for (int i = 0; i < 16; i++)
            cyc(32'(i) << 2, 1'b0, 32'(i) << 2, 1'b1, "R8 ignored");
        for (int i = 0; i < NREG; i++) cyc(32'(i) << 2, 1'b0, '0, 1'b0, "R8 state kept");

        // R4: random traffic over a small aliasing address pool
        for (int i = 0; i < 4000; i++) begin
            logic [PC_W-1:0] p, u;
            bit v, t;
            p = (32'($urandom_range(0, 3)) << 12) | (32'($urandom_range(0, 15)) << 2);
            u = (32'($urandom_range(0, 3)) << 12) | (32'($urandom_range(0, 15)) << 2);
            v = ($urandom_range(0, 3) != 0);
            t = (u[2] ^ u[3]) ? ($urandom_range(0, 9) < 8) : ((i % 3) == 0);
            cyc(p, v, u, t, "R4 random");
        end

        done = 1;
        summary();
        $finish;
    end
endmodule